// File: doc/BRIEF.md
# Sleep Timer with Rollover Watchdog

This block is a free-running sleep timer advanced by a slow periodic tick, typically a 32 kHz enable pulse in a fast clock domain. A two-bit interval code picks the timer's period. Each time the timer wraps, it emits a sleep event. The event reaches the interrupt output only when the sleep bit of an eight-bit interrupt mask is set.

The watchdog has no timebase of its own. It counts timer wraps and issues a one-cycle reset pulse on the third wrap since it was last cleared. Software clears it through a write-only clear register. Most written values restart only the wrap count, so the next timeout lands between two and three periods away depending on the timer's phase. One value, 0x38, restarts the timer as well, which guarantees a full three-period timeout.

The interface is plain control: a write strobe with data, level inputs for the interval code and the mask, and pulse outputs. There is no stream traffic, so no valid/ready handshake and no back-pressure.

Top module: `slpwd_top`

## Requirements
- R1: The interval code selects a period of 2^(BASE_LOG2 + STEP_LOG2*code) ticks. The defaults give 64, 512, 4096 and 32768 ticks for codes 0, 1, 2 and 3. The active code resets to 0, so the first period after reset uses code 0 whatever `ivl_sel` holds.
- R2: The timer advances only in cycles with `tick_en` high. A period of N ticks ends on the clock edge that samples the Nth tick.
- R3: `wdt_rst` pulses high for exactly one cycle. It rises in the cycle after the third wrap event since reset or the last clear, whether or not that wrap was masked.
- R4: A clear-register write of any value other than 0x38 returns the wrap count to zero and leaves the timer phase unchanged.
- R5: A clear-register write of 0x38 returns both the timer and the wrap count to zero. The next wrap then comes a full period after the write edge, and the timeout comes three full periods after it.
- R6: `sleep_irq` pulses for one cycle, in the cycle after the edge that completes a period, only while bit 6 of `irq_mask` is high. The other mask bits have no effect on it.
- R7: A change of `ivl_sel` takes effect at the next wrap, so the period in progress completes at its old length. A 0x38 clear also loads the code.
- R8: During and right after reset, `sleep_irq` and `wdt_rst` are low and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per slow-clock tick |
| clr_wr | input | 1 | Write strobe for the clear register |
| clr_wdata | input | 8 | Value written to the clear register |
| ivl_sel | input | 2 | Interval code for the following periods |
| irq_mask | input | 8 | Interrupt mask; bit 6 enables the sleep interrupt |
| sleep_irq | output | 1 | Sleep interrupt pulse on a timer wrap |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The bench builds the top with BASE_LOG2 = 3 and STEP_LOG2 = 2, which makes the four periods 8, 32, 128 and 512 ticks. This brings the timeout for every code, including the longest, within a short run. At this scale each wrap and timeout edge can be predicted to the exact cycle. That covers the reset-time code, a select change in mid-period, clears that land before and after a wrap, a value that differs from 0x38 in one bit, and a tick that arrives only every third cycle.

// File: rtl/slpwd_pkg.sv
package slpwd_pkg;
  typedef logic [1:0] ivl_code_t;
  localparam int NUM_CODES = 4;
  localparam int WRAPS_TO_FIRE = 3;

  function automatic int period_exp(input int base_log2, input int step_log2, input int code);
    return base_log2 + step_log2 * code;
  endfunction
endpackage

// File: rtl/slpwd_clr_dec.sv
module slpwd_clr_dec #(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  BOTH_CODE = 8'h38
) (
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wd_clr,
  output logic              tmr_clr
);
  // Any write restarts the wrap count; one value restarts the timer too.
  always_comb begin
    wd_clr  = wr;
    tmr_clr = wr && (wdata == DATA_W'(BOTH_CODE));
  end
endmodule

// File: rtl/slpwd_ivl_latch.sv
module slpwd_ivl_latch
  import slpwd_pkg::*;
#(
  parameter int BASE_LOG2 = 6,
  parameter int STEP_LOG2 = 3,
  parameter int CNT_W     = BASE_LOG2 + STEP_LOG2 * (NUM_CODES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  ivl_code_t        sel_in,
  output logic [CNT_W-1:0] last_cnt
);
  ivl_code_t        act_q;
  logic [CNT_W-1:0] last_lut [NUM_CODES];

  // Terminal value per code: all ones across the period's exponent.
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_lut
    localparam int EXP = period_exp(BASE_LOG2, STEP_LOG2, g);
    assign last_lut[g] = CNT_W'((64'd1 << EXP) - 64'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    act_q <= '0;
    else if (load) act_q <= sel_in;
  end

  assign last_cnt = last_lut[act_q];
endmodule

// File: rtl/slpwd_tick_ctr.sv
module slpwd_tick_ctr #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] last_cnt,
  output logic             wrap_now,
  output logic             roll,
  output logic [CNT_W-1:0] cnt
);
  assign wrap_now = tick && (cnt == last_cnt) && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      roll <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      roll <= 1'b0;
    end else begin
      roll <= wrap_now;
      if (wrap_now)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/slpwd_wdt_chain.sv
module slpwd_wdt_chain #(
  parameter int WRAPS = 3,
  localparam int RC_W = $clog2(WRAPS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            roll,
  output logic [RC_W-1:0] roll_cnt,
  output logic            fire
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      roll_cnt <= '0;
      fire     <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (roll) begin
        if (roll_cnt == RC_W'(WRAPS - 1)) begin
          roll_cnt <= '0;
          fire     <= 1'b1;
        end else begin
          roll_cnt <= roll_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/slpwd_top.sv
module slpwd_top
  import slpwd_pkg::*;
#(
  parameter int          BASE_LOG2 = 6,
  parameter int          STEP_LOG2 = 3,
  parameter int          MASK_BIT  = 6,
  parameter logic [7:0]  BOTH_CODE = 8'h38
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       clr_wr,
  input  logic [7:0] clr_wdata,
  input  logic [1:0] ivl_sel,
  input  logic [7:0] irq_mask,
  output logic       sleep_irq,
  output logic       wdt_rst
);
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * (NUM_CODES - 1);
  localparam int RC_W  = $clog2(WRAPS_TO_FIRE + 1);

  logic             wd_clr, tmr_clr, wrap_now, roll_q;
  logic [CNT_W-1:0] last_cnt, cnt_q;
  logic [RC_W-1:0]  roll_cnt;

  slpwd_clr_dec #(.DATA_W(8), .BOTH_CODE(BOTH_CODE)) u_dec (
    .wr(clr_wr), .wdata(clr_wdata), .wd_clr(wd_clr), .tmr_clr(tmr_clr)
  );

  slpwd_ivl_latch #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .CNT_W(CNT_W)) u_ivl (
    .clk(clk), .rst_n(rst_n), .load(wrap_now || tmr_clr),
    .sel_in(ivl_sel), .last_cnt(last_cnt)
  );

  slpwd_tick_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .clr(tmr_clr),
    .last_cnt(last_cnt), .wrap_now(wrap_now), .roll(roll_q), .cnt(cnt_q)
  );

  slpwd_wdt_chain #(.WRAPS(WRAPS_TO_FIRE)) u_wdt (
    .clk(clk), .rst_n(rst_n), .clr(wd_clr), .roll(roll_q),
    .roll_cnt(roll_cnt), .fire(wdt_rst)
  );

  assign sleep_irq = roll_q && irq_mask[MASK_BIT];
endmodule

// File: rtl/slpwd_chk.sv
module slpwd_chk #(
  parameter int         CNT_W     = 15,
  parameter int         RC_W      = 2,
  parameter int         MASK_BIT  = 6,
  parameter logic [7:0] BOTH_CODE = 8'h38
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             clr_wr,
  input logic [7:0]       clr_wdata,
  input logic [7:0]       irq_mask,
  input logic             sleep_irq,
  input logic             wdt_rst,
  input logic             roll,
  input logic [CNT_W-1:0] cnt,
  input logic [RC_W-1:0]  roll_cnt
);
  p_roll_at_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    roll |-> (cnt == '0));

  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr_wr) |=> $stable(cnt));

  p_wdt_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  p_wdt_after_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(roll));

  p_any_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (roll_cnt == '0 && !wdt_rst));

  p_both_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_wdata == BOTH_CODE) |=> (cnt == '0 && !roll));

  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_irq |-> irq_mask[MASK_BIT]);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    roll_cnt < RC_W'(3));
endmodule

bind slpwd_top slpwd_chk #(
  .CNT_W(CNT_W), .RC_W(RC_W), .MASK_BIT(MASK_BIT), .BOTH_CODE(BOTH_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr_wr(clr_wr),
  .clr_wdata(clr_wdata), .irq_mask(irq_mask), .sleep_irq(sleep_irq),
  .wdt_rst(wdt_rst), .roll(roll_q), .cnt(cnt_q), .roll_cnt(roll_cnt)
);

// File: tb/slpwd_top_bench.sv
module slpwd_top_bench;
  localparam int BASE = 3;
  localparam int STEP = 2;

  typedef struct {
    int    cyc;
    bit    is_wdt;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en;
  logic       clr_wr = 1'b0;
  logic [7:0] clr_wdata = 8'h00;
  logic [1:0] ivl_sel = 2'd2;
  logic [7:0] irq_mask = 8'h40;
  logic       sleep_irq, wdt_rst;

  int   cyc = 0;
  int   tdiv = 1;
  int   tests = 0;
  int   fails = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Ticks land on edges whose index is a multiple of tdiv (R2).
  assign tick_en = ((cyc + 1) % tdiv) == 0;

  slpwd_top #(.BASE_LOG2(BASE), .STEP_LOG2(STEP)) u_slpwd_top (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr_wr(clr_wr),
    .clr_wdata(clr_wdata), .ivl_sel(ivl_sel), .irq_mask(irq_mask),
    .sleep_irq(sleep_irq), .wdt_rst(wdt_rst)
  );

  function automatic int tlen(input int code);
    return 1 << (BASE + STEP * code);
  endfunction

  task automatic push(input int c, input bit w, input string r);
    exp_t e;
    e.cyc = c; e.is_wdt = w; e.req = r;
    q.push_back(e);
  endtask

  function automatic void observe(input bit w);
    exp_t e;
    tests++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL unexpected %s at cycle %0d (expected none)", w ? "wdt_rst" : "sleep_irq", cyc);
    end else begin
      e = q.pop_front();
      if (e.cyc != cyc || e.is_wdt != w) begin
        fails++;
        $display("FAIL %s: got %s at cycle %0d, expected %s at cycle %0d", e.req,
                 w ? "wdt_rst" : "sleep_irq", cyc, e.is_wdt ? "wdt_rst" : "sleep_irq", e.cyc);
      end
    end
  endfunction

  // Monitor: samples away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (q.size() != 0 && q[0].cyc < cyc) begin
        exp_t e;
        e = q.pop_front();
        tests++; fails++;
        $display("FAIL %s: missed %s, actual none, expected at cycle %0d", e.req,
                 e.is_wdt ? "wdt_rst" : "sleep_irq", e.cyc);
      end
      if (sleep_irq) observe(1'b0);
      if (wdt_rst)   observe(1'b1);
    end
  end

  task automatic tick_at(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic write_at(input int c, input logic [7:0] d);
    tick_at(c - 1);
    clr_wr = 1'b1; clr_wdata = d;
    @(negedge clk);
    clr_wr = 1'b0;
  endtask

  task automatic clear_both(output int e);
    while (((cyc + 1) % tdiv) != 0) @(negedge clk);
    e = cyc + 1;
    write_at(e, 8'h38);
  endtask

  task automatic drain(input string r);
    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d events outstanding, expected 0", r, q.size());
      q.delete();
    end
  endtask

  task automatic full_run(input int code, input logic [7:0] msk, input bit want_irq, input string r);
    int e, t;
    ivl_sel = 2'(code); irq_mask = msk;
    clear_both(e);
    t = tlen(code) * tdiv;
    for (int k = 1; k <= 3; k++) if (want_irq) push(e + k * t, 1'b0, r);
    push(e + 3 * t + 1, 1'b1, r);
    tick_at(e + 3 * t + 2);
    drain(r);
  endtask

  initial begin
    int e, e2;
    repeat (3) @(negedge clk);
    // R8: reset state
    tests++;
    if (sleep_irq !== 1'b0 || wdt_rst !== 1'b0) begin
      fails++;
      $display("FAIL R8: irq=%b wdt=%b, expected 0 0", sleep_irq, wdt_rst);
    end
    // R1/R7: first period uses code 0 although ivl_sel=2
    push(8, 1'b0, "R1"); push(136, 1'b0, "R1"); push(264, 1'b0, "R1");
    push(265, 1'b1, "R3");
    rst_n = 1'b1;
    tick_at(266);
    drain("R1");

    // R1/R3/R5: each interval code, full timeout
    full_run(0, 8'h40, 1'b1, "R1_code0");
    full_run(1, 8'h40, 1'b1, "R1_code1");
    full_run(2, 8'h40, 1'b1, "R1_code2");
    full_run(3, 8'h40, 1'b1, "R1_code3");

    // R6: bit 6 clear, all other bits set: no interrupts, watchdog still fires
    full_run(0, 8'hBF, 1'b0, "R6_masked");
    full_run(0, 8'h40, 1'b1, "R6_only_bit6");

    // R2: tick every third cycle
    tdiv = 3;
    full_run(0, 8'h40, 1'b1, "R2_slow_tick");
    tdiv = 1;

    // R4: plain clear after the first wrap pushes the timeout out
    ivl_sel = 2'd0; irq_mask = 8'h40;
    clear_both(e);
    push(e + 8, 1'b0, "R4");
    write_at(e + 11, 8'h55);
    push(e + 16, 1'b0, "R4"); push(e + 24, 1'b0, "R4"); push(e + 32, 1'b0, "R4");
    push(e + 33, 1'b1, "R4");
    tick_at(e + 34);
    drain("R4");

    // R4: 0x39 leaves the timer phase alone
    clear_both(e);
    write_at(e + 6, 8'h39);
    push(e + 8, 1'b0, "R4_0x39"); push(e + 16, 1'b0, "R4_0x39"); push(e + 24, 1'b0, "R4_0x39");
    push(e + 25, 1'b1, "R4_0x39");
    tick_at(e + 26);
    drain("R4_0x39");

    // R5: 0x38 in mid-period restarts the timer
    clear_both(e);
    push(e + 8, 1'b0, "R5");
    e2 = e + 11;
    write_at(e2, 8'h38);
    push(e2 + 8, 1'b0, "R5"); push(e2 + 16, 1'b0, "R5"); push(e2 + 24, 1'b0, "R5");
    push(e2 + 25, 1'b1, "R5");
    tick_at(e2 + 26);
    drain("R5");

    // R7: select change mid-period applies from the next wrap
    ivl_sel = 2'd0;
    clear_both(e);
    tick_at(e + 2);
    ivl_sel = 2'd1;
    push(e + 8, 1'b0, "R7"); push(e + 40, 1'b0, "R7"); push(e + 72, 1'b0, "R7");
    push(e + 73, 1'b1, "R7");
    tick_at(e + 74);
    drain("R7");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: run hung, actual incomplete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule